// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Arbiter

This block gathers a set of peripheral interrupt channels and turns them into one service request for the processor core. Each channel holds four fields: a pending flag, a mask flag, a three-bit priority level and a vector of up to seven bits. Each channel's trigger input sets its pending flag. Software can also set or clear that flag through the per-channel write port, and can read it back through the read port to poll it.

Every cycle a channel qualifies when its pending flag, its mask flag and the global enable are all 1 and its level is not the reserved level 7. Among the qualifying channels, the one with the numerically lowest level wins. The winner is offered to the core only if its level is strictly lower than the core's current level and the block-all input is low. When the core acknowledges a request, the winner's pending flag is cleared and its vector is shown on the vector output for one cycle.

Top module: `pirq_arbiter`

## Requirements
- R1: After synchronous reset, every channel field reads 0, and `req_o` and `vec_valid_o` are 0.
- R2: A trigger pulse on channel n sets its pending flag. The flag reads back as bit 11 of `rd_data_o` one cycle after `rd_ch_i` selects n. In the default layout, bit 10 is the mask, bits 9:7 are the level and bits 6:0 are the vector.
- R3: A write sets all four fields of the addressed channel, so software can raise or cancel a pending flag. If the trigger and a write that clears the flag land in the same cycle, the trigger wins.
- R4: A channel asks for service only when its pending flag, its mask flag and `gie_i` are all 1. A mask of 0, or `gie_i` low, blocks it.
- R5: A channel at level 7 never causes `req_o`, even when it is pending, unmasked and enabled.
- R6: The qualifying channel with the lowest numeric level wins. On a tie, the lowest channel index wins.
- R7: `req_o` rises only when the winning level is strictly lower than `cpu_prio_i`.
- R8: While `block_all_i` is 1, `req_o` stays 0.
- R9: If `ack_i` is high while `req_o` is high, three things happen on the next cycle: the winner's pending flag is cleared, `vec_valid_o` is 1 for exactly that cycle with `vec_o` equal to the winner's vector, and `req_o` is 0.
- R10: An `ack_i` while `req_o` is 0 has no effect. No pending flag changes and `vec_valid_o` stays 0.
- R11: `req_o` is registered. It follows a change of channel state, enables or the core level one clock after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NUM_CH | Per-channel trigger events |
| gie_i | input | 1 | Global interrupt enable |
| block_all_i | input | 1 | Suppresses every request (top-level service active) |
| cpu_prio_i | input | 3 | Current core priority level |
| wr_en_i | input | 1 | Channel register write strobe |
| wr_ch_i | input | IDX_W | Channel addressed by the write |
| wr_data_i | input | CFG_W | {pending, mask, level, vector} |
| rd_ch_i | input | IDX_W | Channel addressed by the read |
| rd_data_o | output | CFG_W | Registered read of the selected channel |
| req_o | output | 1 | Request to the core |
| ack_i | input | 1 | Core acknowledge |
| vec_valid_o | output | 1 | One-cycle vector strobe after an accepted acknowledge |
| vec_o | output | VEC_W | Vector of the acknowledged channel |

## Verification
The hardest cases to reach from the ports are ties between channels at the same level and winners that sit exactly one level below `cpu_prio_i`. These cases also have to appear together with masked-off and level-7 channels that would otherwise win. The bench writes a fresh configuration to every channel each round, drawing all fields from a small arithmetic generator, and sweeps `cpu_prio_i` through every value. It predicts the winner with its own arithmetic model and then acknowledges it, so the same rounds also exercise the pending-flag clear and the vector strobe.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PRIO_W = 3;
  localparam logic [PRIO_W-1:0] PRIO_MUTE = 3'd7;

  function automatic logic beats(input logic [PRIO_W-1:0] a, input logic [PRIO_W-1:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/pirq_chan.sv
module pirq_chan
  import pirq_pkg::*;
#(
  parameter int VEC_W = 7,
  localparam int CFG_W = VEC_W + PRIO_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              wr_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic              ack_clr_i,
  output logic              pend_o,
  output logic              mask_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic pend_next;

  // hardware trigger beats a software clear and the acknowledge clear
  always_comb begin
    if (trig_i)         pend_next = 1'b1;
    else if (wr_i)      pend_next = wr_data_i[CFG_W-1];
    else if (ack_clr_i) pend_next = 1'b0;
    else                pend_next = pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      mask_o <= 1'b0;
      prio_o <= '0;
      vec_o  <= '0;
    end else begin
      pend_o <= pend_next;
      if (wr_i) begin
        mask_o <= wr_data_i[CFG_W-2];
        prio_o <= wr_data_i[VEC_W +: PRIO_W];
        vec_o  <= wr_data_i[VEC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pirq_select.sv
module pirq_select
  import pirq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        pend_i,
  input  logic [NUM_CH-1:0]        mask_i,
  input  logic                     gie_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH*VEC_W-1:0]  vec_i,
  output logic                     found_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [PRIO_W-1:0]        prio_o,
  output logic [VEC_W-1:0]         vec_o
);
  logic [NUM_CH-1:0] cand;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
    assign cand[g] = pend_i[g] & mask_i[g] & gie_i &
                     (prio_i[g*PRIO_W +: PRIO_W] != PRIO_MUTE);
  end

  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = PRIO_MUTE;
    vec_o   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand[i] && (!found_o || beats(prio_i[i*PRIO_W +: PRIO_W], prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
        vec_o   = vec_i[i*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/pirq_out_stage.sv
module pirq_out_stage
  import pirq_pkg::*;
#(
  parameter int VEC_W = 7,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0] cpu_prio_i,
  input  logic              block_all_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              take_o,
  output logic [IDX_W-1:0]  held_idx_o,
  output logic [PRIO_W-1:0] held_prio_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [VEC_W-1:0] held_vec;
  logic             offer;

  assign take_o = ack_i & req_o;
  assign offer  = found_i & beats(prio_i, cpu_prio_i) & ~block_all_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o       <= 1'b0;
      held_idx_o  <= '0;
      held_prio_o <= PRIO_MUTE;
      held_vec    <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      req_o       <= offer & ~take_o;
      held_idx_o  <= idx_i;
      held_prio_o <= prio_i;
      held_vec    <= vec_i;
      vec_valid_o <= take_o;
      if (take_o) vec_o <= held_vec;
    end
  end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
  import pirq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CFG_W = VEC_W + PRIO_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic              gie_i,
  input  logic              block_all_i,
  input  logic [PRIO_W-1:0] cpu_prio_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_ch_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]  rd_ch_i,
  output logic [CFG_W-1:0]  rd_data_o,
  output logic              req_o,
  input  logic              ack_i,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NUM_CH-1:0]        pend, mask;
  logic [NUM_CH*PRIO_W-1:0] prio_flat;
  logic [NUM_CH*VEC_W-1:0]  vec_flat;
  logic                     found;
  logic [IDX_W-1:0]         sel_idx, held_idx;
  logic [PRIO_W-1:0]        sel_prio, held_prio;
  logic [VEC_W-1:0]         sel_vec;
  logic                     take;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en_i && (wr_ch_i == IDX_W'(g));
    assign clr_hit = take && (held_idx == IDX_W'(g));
    pirq_chan #(.VEC_W(VEC_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .trig_i    (trig_i[g]),
      .wr_i      (wr_hit),
      .wr_data_i (wr_data_i),
      .ack_clr_i (clr_hit),
      .pend_o    (pend[g]),
      .mask_o    (mask[g]),
      .prio_o    (prio_flat[g*PRIO_W +: PRIO_W]),
      .vec_o     (vec_flat[g*VEC_W +: VEC_W])
    );
  end

  pirq_select #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_sel (
    .pend_i  (pend),
    .mask_i  (mask),
    .gie_i   (gie_i),
    .prio_i  (prio_flat),
    .vec_i   (vec_flat),
    .found_o (found),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio),
    .vec_o   (sel_vec)
  );

  pirq_out_stage #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .found_i     (found),
    .idx_i       (sel_idx),
    .prio_i      (sel_prio),
    .vec_i       (sel_vec),
    .cpu_prio_i  (cpu_prio_i),
    .block_all_i (block_all_i),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .take_o      (take),
    .held_idx_o  (held_idx),
    .held_prio_o (held_prio),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
  );

  // registered polling port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      rd_data_o <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        if (rd_ch_i == IDX_W'(i))
          rd_data_o <= {pend[i], mask[i], prio_flat[i*PRIO_W +: PRIO_W], vec_flat[i*VEC_W +: VEC_W]};
      end
    end
  end
endmodule

// File: rtl/pirq_arbiter_chk.sv
module pirq_arbiter_chk
  import pirq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              gie_i,
  input logic              block_all_i,
  input logic [PRIO_W-1:0] cpu_prio_i,
  input logic              req_o,
  input logic              ack_i,
  input logic              vec_valid_o,
  input logic [PRIO_W-1:0] held_prio
);
  // R4
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(gie_i));

  // R8
  block_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !$past(block_all_i));

  // R7
  level_beat_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (held_prio < $past(cpu_prio_i)));

  // R5
  mute_level_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (held_prio != PRIO_MUTE));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_o) |=> (!req_o && vec_valid_o));

  // R10
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(ack_i && req_o));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> !vec_valid_o);
endmodule

bind pirq_arbiter pirq_arbiter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .gie_i       (gie_i),
  .block_all_i (block_all_i),
  .cpu_prio_i  (cpu_prio_i),
  .req_o       (req_o),
  .ack_i       (ack_i),
  .vec_valid_o (vec_valid_o),
  .held_prio   (held_prio)
);

// File: tb/pirq_arbiter_test.sv
module pirq_arbiter_test;
  localparam int NCH = 4;
  localparam int VW  = 7;
  localparam int IW  = 2;
  localparam int CW  = VW + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] trig_i = '0;
  logic gie_i = 1'b0, block_all_i = 1'b0, wr_en_i = 1'b0, ack_i = 1'b0;
  logic [2:0] cpu_prio_i = 3'd7;
  logic [IW-1:0] wr_ch_i = '0, rd_ch_i = '0;
  logic [CW-1:0] wr_data_i = '0;
  logic [CW-1:0] rd_data_o;
  logic req_o, vec_valid_o;
  logic [VW-1:0] vec_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic       m_pend [NCH];
  logic       m_mask [NCH];
  logic [2:0] m_prio [NCH];
  logic [6:0] m_vec  [NCH];

  always #2 clk = ~clk;

  pirq_arbiter #(.NUM_CH(NCH), .VEC_W(VW)) uut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic p, input logic m, input logic [2:0] pr, input logic [6:0] v);
    wr_en_i = 1'b1; wr_ch_i = IW'(ch); wr_data_i = {p, m, pr, v};
    m_pend[ch] = p; m_mask[ch] = m; m_prio[ch] = pr; m_vec[ch] = v;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int ch);
    rd_ch_i = IW'(ch);
    tick();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // model: returns winner index, or -1 when nothing is offered
  function automatic int model();
    int best = -1;
    for (int i = 0; i < NCH; i++)
      if (m_pend[i] && m_mask[i] && gie_i && m_prio[i] != 3'd7)
        if (best < 0 || m_prio[i] < m_prio[best]) best = i;
    if (best >= 0 && (m_prio[best] >= cpu_prio_i || block_all_i)) best = -1;
    return best;
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_mask[i] = 0; m_prio[i] = 0; m_vec[i] = 0; end
    tick(); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 req", req_o, 0);
    chk("R1 vvalid", vec_valid_o, 0);
    for (int c = 0; c < NCH; c++) begin rd(c); chk("R1 cfg", rd_data_o, 0); end

    // R2 trigger sets pending (bit 11)
    trig_i = 4'b0100; tick(); trig_i = '0;
    rd(2); chk("R2 pend", rd_data_o[11], 1);
    m_pend[2] = 1;
    rd(1); chk("R2 other", rd_data_o[11], 0);

    // R3 software write and trigger precedence
    wr(1, 1, 1, 3'd4, 7'h15);
    rd(1); chk("R3 write", rd_data_o, {1'b1, 1'b1, 3'd4, 7'h15});
    wr(1, 0, 1, 3'd4, 7'h15);
    rd(1); chk("R3 cancel", rd_data_o[11], 0);
    trig_i = 4'b0010; wr(1, 0, 1, 3'd4, 7'h15); trig_i = '0; m_pend[1] = 1;
    rd(1); chk("R3 trig wins", rd_data_o[11], 1);

    // R4 gie / mask gating; channel 2 still masked
    gie_i = 1'b0; tick(); tick();
    chk("R4 gie off", req_o, 0);
    // R10 ack with no request is ignored
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R10 no strobe", vec_valid_o, 0);
    rd(1); chk("R10 pend kept", rd_data_o[11], 1);
    gie_i = 1'b1; tick();
    // R11 one clock after gie rises
    chk("R11 latency", req_o, 1);
    wr(1, 1, 0, 3'd4, 7'h15); tick();
    chk("R4 mask off", req_o, 0);

    // R5 level 7 never offered
    wr(1, 1, 1, 3'd7, 7'h15); tick(); tick();
    chk("R5 mute", req_o, 0);

    // R6 tie goes to lowest index
    wr(3, 1, 1, 3'd2, 7'h33);
    wr(1, 1, 1, 3'd2, 7'h11);
    tick();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R6 tie vec", vec_o, 7'h11);

    // R8 block-all suppresses
    block_all_i = 1'b1; tick(); tick();
    chk("R8 block", req_o, 0);
    block_all_i = 1'b0; tick();
    chk("R8 release", req_o, 1);

    // R7 strict level compare at the boundary
    cpu_prio_i = 3'd2; tick(); tick();
    chk("R7 equal", req_o, 0);
    cpu_prio_i = 3'd3; tick();
    chk("R7 below", req_o, 1);

    // sweep: R6 R7 R9 with arithmetic model
    for (int it = 0; it < 600; it++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] r = rnd();
        wr(c, r[0] | r[1], r[2] | r[3], r[6:4], r[13:7]);
      end
      begin
        logic [31:0] r = rnd();
        gie_i = (r[3:0] != 0);
        block_all_i = (r[7:4] == 0);
        cpu_prio_i = 3'(it % 8);
      end
      tick();
      begin
        int w = model();
        chk("R7 sweep req", req_o, (w >= 0));
        if (w >= 0) begin
          ack_i = 1'b1; tick(); ack_i = 1'b0;
          chk("R9 strobe", vec_valid_o, 1);
          chk("R6 sweep vec", vec_o, m_vec[w]);
          chk("R9 req drop", req_o, 0);
          m_pend[w] = 0;
          rd(w);
          chk("R9 cleared", rd_data_o[11], 0);
          chk("R9 one cycle", vec_valid_o, 0);
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule